// File: doc/BRIEF.md
# Generation-Bit Event Queue Writer

This block posts interrupt events into eight circular queues held in memory. Each queue belongs to one priority level. An incoming event carries a logical interrupt number and a priority. The priority picks the queue. The block turns the event into one 32-bit entry, writes it through a simple single-cycle write port into the next free slot of that queue, and then moves that queue's write index on by one.

There is no shared head or tail register. Each entry holds a generation bit that flips every time its queue wraps. A consumer polls the slot it expects to be next and compares that bit with the generation it expects. A freshly zeroed queue reads as empty, because the first pass writes the bit as 1.

Each queue has its own enable and its own base page. The base page is a 4 KiB aligned page number, so each queue holds 1024 entries. An event sent to a disabled queue writes nothing. It sets a sticky drop flag for that queue instead.

Top module: `evq_poster`

## Requirements
- R1: Each event presented with `evtValid` high to an enabled queue produces exactly one cycle of `memWrEn` high, on the clock edge after the one that sampled it. No other cycle has `memWrEn` high.
- R2: The write address is the queue's base page, followed by the 10-bit slot index, followed by two zero bits. This equals base page × 4096 + index × 4. The base page of priority p is the field `qBasePages[p*PAGE_W +: PAGE_W]`.
- R3: The written entry has the generation bit in bit 31 and the logical interrupt number zero-extended in bits 30:0.
- R4: Each accepted event advances only its own queue's slot index, by one. The other seven queues keep their indices.
- R5: After slot 1023 the index returns to 0, and that queue's generation bit inverts for every following entry until the next wrap.
- R6: After reset, the first entry written to a queue goes to slot 0 with generation bit 1.
- R7: While a queue's enable bit is low, its index is held at 0 and its generation at 1. When the queue is enabled again, it restarts at slot 0 with generation 1.
- R8: An event to a disabled queue produces no memory write. It sets `dropFlag` for that priority, and the flag stays set until reset.
- R9: During reset `memWrEn` is low and all drop flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtValid | input | 1 | Event present this cycle |
| evtPrio | input | 3 | Event priority, selects the queue |
| evtIrq | input | IRQ_W (10) | Logical interrupt number |
| qEnable | input | 8 | Per-queue enable, bit p for priority p |
| qBasePages | input | 8*PAGE_W (160) | Per-queue 4 KiB base page numbers, packed by priority |
| memWrEn | output | 1 | Memory write strobe |
| memAddr | output | 32 | Byte address of the entry |
| memData | output | 32 | Entry written |
| dropFlag | output | 8 | Sticky per-queue drop indication |

## Verification
The assertions take two things for granted about the inputs:
- `evtPrio` and `qEnable` are stable from one edge to the next.
- An event can arrive on any cycle, including back to back to the same queue.

The assertions place no limit on how often enables toggle. The bench changes inputs only at the falling clock edge. Its random stream toggles single enable bits rarely, so runs of posts to each queue are long, and it sometimes changes base pages between events. Wrap behaviour is reached by directed runs of more than 1024 posts to one priority. Random stimulus alone would not fill a 1024-entry queue.

// File: rtl/evq_pkg.sv
package evq_pkg;
  localparam int NUM_Q   = 8;
  localparam int PRIO_W  = $clog2(NUM_Q);
  localparam int IDX_W   = 10;
  localparam int ENTRY_W = 32;

  // Strobes from control to datapath
  typedef struct packed {
    logic              post;
    logic              drop;
    logic [PRIO_W-1:0] prio;
  } evq_strobe_t;
endpackage

// File: rtl/evq_ctrl.sv
module evq_ctrl
  import evq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtValid,
  input  logic [PRIO_W-1:0] evtPrio,
  input  logic [NUM_Q-1:0]  qEnable,
  output evq_strobe_t       strb,
  output logic [NUM_Q-1:0]  dropFlag
);
  logic selEnabled;

  assign selEnabled = qEnable[evtPrio];

  always_comb begin
    strb.post = evtValid & selEnabled;
    strb.drop = evtValid & ~selEnabled;
    strb.prio = evtPrio;
  end

  for (genvar q = 0; q < NUM_Q; q++) begin : gDrop
    always_ff @(posedge clk) begin
      if (!rstN)
        dropFlag[q] <= 1'b0;
      else if (strb.drop && (strb.prio == PRIO_W'(q)))
        dropFlag[q] <= 1'b1;
    end

    // R8
    drop_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
      dropFlag[q] |=> dropFlag[q]);
  end
endmodule

// File: rtl/evq_datapath.sv
module evq_datapath
  import evq_pkg::*;
#(
  parameter int PAGE_W = 20,
  parameter int IRQ_W  = 10,
  localparam int ADDR_W = PAGE_W + IDX_W + 2
)(
  input  logic                    clk,
  input  logic                    rstN,
  input  evq_strobe_t             strb,
  input  logic [NUM_Q-1:0]        qEnable,
  input  logic [IRQ_W-1:0]        evtIrq,
  input  logic [NUM_Q*PAGE_W-1:0] qBasePages,
  output logic                    memWrEn,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [ENTRY_W-1:0]      memData
);
  localparam int PAD_W = ENTRY_W - 1 - IRQ_W;
  localparam logic [IDX_W-1:0] LAST_IDX = '1;

  logic [IDX_W-1:0]  idxQ  [NUM_Q];
  logic              genQ  [NUM_Q];
  logic [PAGE_W-1:0] pageQ [NUM_Q];

  for (genvar q = 0; q < NUM_Q; q++) begin : gQueue
    logic hit;
    assign hit = strb.post && (strb.prio == PRIO_W'(q));
    assign pageQ[q] = qBasePages[q*PAGE_W +: PAGE_W];

    always_ff @(posedge clk) begin
      if (!rstN || !qEnable[q]) begin
        idxQ[q] <= '0;
        genQ[q] <= 1'b1;
      end else if (hit) begin
        idxQ[q] <= idxQ[q] + 1'b1;
        if (idxQ[q] == LAST_IDX)
          genQ[q] <= ~genQ[q];
      end
    end

    // R7
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !qEnable[q] |=> (idxQ[q] == '0 && genQ[q]));
    // R5
    gen_flip_at_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
      (qEnable[q] && $past(qEnable[q]) && genQ[q] != $past(genQ[q])) |-> idxQ[q] == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memWrEn <= 1'b0;
      memAddr <= '0;
      memData <= '0;
    end else begin
      memWrEn <= strb.post;
      if (strb.post) begin
        memAddr <= {pageQ[strb.prio], idxQ[strb.prio], 2'b00};
        memData <= {genQ[strb.prio], {PAD_W{1'b0}}, evtIrq};
      end
    end
  end

  // R1
  post_to_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.post |=> memWrEn);
  // R1
  no_spurious_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.post |=> !memWrEn);
endmodule

// File: rtl/evq_poster.sv
module evq_poster
  import evq_pkg::*;
#(
  parameter int PAGE_W = 20,
  parameter int IRQ_W  = 10,
  localparam int ADDR_W = PAGE_W + IDX_W + 2
)(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    evtValid,
  input  logic [PRIO_W-1:0]       evtPrio,
  input  logic [IRQ_W-1:0]        evtIrq,
  input  logic [NUM_Q-1:0]        qEnable,
  input  logic [NUM_Q*PAGE_W-1:0] qBasePages,
  output logic                    memWrEn,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [ENTRY_W-1:0]      memData,
  output logic [NUM_Q-1:0]        dropFlag
);
  evq_strobe_t strb;

  evq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtPrio(evtPrio),
    .qEnable(qEnable), .strb(strb), .dropFlag(dropFlag)
  );

  evq_datapath #(.PAGE_W(PAGE_W), .IRQ_W(IRQ_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .qEnable(qEnable),
    .evtIrq(evtIrq), .qBasePages(qBasePages),
    .memWrEn(memWrEn), .memAddr(memAddr), .memData(memData)
  );

  // R8
  disabled_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && !qEnable[evtPrio]) |=> !memWrEn);
  // R8
  disabled_sets_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && !qEnable[evtPrio]) |=> dropFlag[$past(evtPrio)]);
endmodule

// File: tb/evq_poster_test.sv
`timescale 1ns/1ps
module evq_poster_test;
  localparam int NQ = 8;
  localparam int PW = 20;

  logic clk = 1'b0;
  logic rstN;
  logic evtValid;
  logic [2:0] evtPrio;
  logic [9:0] evtIrq;
  logic [NQ-1:0] qEnable;
  logic [NQ*PW-1:0] qBasePages;
  logic memWrEn;
  logic [31:0] memAddr, memData;
  logic [NQ-1:0] dropFlag;

  always #2 clk = ~clk;

  evq_poster uut (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtPrio(evtPrio),
    .evtIrq(evtIrq), .qEnable(qEnable), .qBasePages(qBasePages),
    .memWrEn(memWrEn), .memAddr(memAddr), .memData(memData),
    .dropFlag(dropFlag)
  );

  int checks = 0;
  int fails = 0;
  int refIdx [NQ];
  bit refGen [NQ];
  bit [NQ-1:0] refDrop;
  bit expWr;
  logic [31:0] expAddr, expData;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] entryOf(bit g, logic [9:0] irq);
    return {g, 21'd0, irq};
  endfunction

  function automatic logic [31:0] addrOf(int p, int idx);
    return {qBasePages[p*PW +: PW], 10'(idx), 2'b00};
  endfunction

  // Drive one cycle at negedge, update the model, check after the next posedge.
  task automatic step(bit v, int p, logic [9:0] irq);
    evtValid = v;
    evtPrio  = 3'(p);
    evtIrq   = irq;
    expWr = 1'b0;
    if (v) begin
      if (qEnable[p]) begin
        expWr   = 1'b1;
        expAddr = addrOf(p, refIdx[p]);
        expData = entryOf(refGen[p], irq);
        refIdx[p] = (refIdx[p] + 1) % 1024;
        if (refIdx[p] == 0) refGen[p] = ~refGen[p];
      end else begin
        refDrop[p] = 1'b1;
      end
    end
    for (int q = 0; q < NQ; q++)
      if (!qEnable[q]) begin refIdx[q] = 0; refGen[q] = 1'b1; end
    @(posedge clk);
    @(negedge clk);
    evtValid = 1'b0;
    check("R1 write strobe", 32'(memWrEn), 32'(expWr));
    if (expWr) begin
      check("R2 address", memAddr, expAddr);
      check("R3 entry", memData, expData);
    end
    check("R8 drop flags", 32'(dropFlag), 32'(refDrop));
  endtask

  bit done = 1'b0;

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rstN = 1'b0; evtValid = 1'b0; evtPrio = '0; evtIrq = '0;
    qEnable = '1;
    for (int q = 0; q < NQ; q++) begin
      qBasePages[q*PW +: PW] = 20'($urandom);
      refIdx[q] = 0; refGen[q] = 1'b1;
    end
    refDrop = '0;
    // R9: reset state; an event during reset must not write
    @(negedge clk); evtValid = 1'b1; evtPrio = 3'd1;
    repeat (4) @(negedge clk);
    check("R9 no write in reset", 32'(memWrEn), 32'd0);
    check("R9 flags clear in reset", 32'(dropFlag), 32'd0);
    evtValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);

    // R6: first entry at slot 0, generation 1
    step(1, 2, 10'd7);
    check("R6 first slot", memAddr, addrOf(2, 0));
    check("R6 first gen", 32'(memData[31]), 32'd1);
    // R4: independent indices
    step(1, 3, 10'd9);
    check("R4 other queue slot 0", memAddr, addrOf(3, 0));
    step(1, 2, 10'd11);
    check("R4 own queue slot 1", memAddr, addrOf(2, 1));

    // R8: drop to disabled queue, flag stays set after re-enable
    qEnable[4] = 1'b0;
    step(1, 4, 10'd3);
    check("R8 no write when disabled", 32'(memWrEn), 32'd0);
    check("R8 flag set", 32'(dropFlag[4]), 32'd1);
    qEnable[4] = 1'b1;
    step(1, 0, 10'd1);
    check("R8 flag sticky", 32'(dropFlag[4]), 32'd1);

    // R7: disabling queue 2 restarts it
    qEnable[2] = 1'b0;
    step(0, 0, 10'd0);
    qEnable[2] = 1'b1;
    step(1, 2, 10'd21);
    check("R7 restart slot", memAddr, addrOf(2, 0));
    check("R7 restart gen", 32'(memData[31]), 32'd1);

    // R5: wrap of queue 5, twice
    for (int i = 0; i < 1023; i++) step(1, 5, 10'(i));
    step(1, 5, 10'd1023);
    check("R5 last slot", memAddr, addrOf(5, 1023));
    check("R5 last gen", 32'(memData[31]), 32'd1);
    step(1, 5, 10'd5);
    check("R5 wrapped slot", memAddr, addrOf(5, 0));
    check("R5 flipped gen", 32'(memData[31]), 32'd0);
    for (int i = 0; i < 1023; i++) step(1, 5, 10'(i));
    step(1, 5, 10'd6);
    check("R5 second wrap gen", 32'(memData[31]), 32'd1);

    // Random traffic
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 50 == 0) qEnable[$urandom % NQ] ^= 1'b1;
      if ($urandom % 100 == 0) qBasePages[($urandom % NQ)*PW +: PW] = 20'($urandom);
      step(($urandom % 4) != 0, int'($urandom % NQ), 10'($urandom));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule